// File: doc/BRIEF.md
# Machine Status Word Controller

This block keeps a 16-bit machine status word and carries out its load and store operations. It applies the masking rules of three processor generations, and a two-bit input picks the generation. Each load comes with the current privilege level and the virtual-8086 flag. The block decides whether the load may proceed. If the load is refused, the word stays as it is and a one-cycle fault strobe is raised.

Bit 0 is the protection-enable bit. Once it is set, no load can clear it. A separate output always shows whether protected mode is on. The store value is read combinationally from the held word, with the fill pattern of the selected generation.

Top module: `msw_ctrl`

## Requirements
- R1: After reset the word is 0x0000, `pmode_on` is low and `prot_fault` is low. With generation code 2 the store value reads 0x0000.
- R2: Generation codes are: 0 oldest, 1 middle, 2 newest. Code 3 behaves as newest. On the newest generation, an accepted load writes the operand unchanged, except for the sticky bit 0 of R5. The new word is visible at `store_val` after the clock edge that samples `load_req`.
- R3: A load is refused when bit 0 of the word is already set and either `priv_lvl` is nonzero or `v86_mode` is high. A refused load leaves the word unchanged.
- R4: `prot_fault` rises on the edge that samples a refused load. It lasts exactly one cycle unless another refused load follows at once.
- R5: While bit 0 of the word is set, an accepted load writes bit 0 as 1, whatever the operand holds.
- R6: On the middle generation (code 1), bit 4 of the new word keeps its previous value, whatever the operand holds.
- R7: On the oldest generation (code 0), bits 15:4 of the new word are cleared.
- R8: `store_val` shows the word itself on the newest generation, the word OR 0xFF00 on the middle generation, and the word OR 0xFFF0 on the oldest.
- R9: `pmode_on` is equal to bit 0 of the word at every cycle.
- R10: While `load_req` is low, the word does not change, whatever `load_val`, `priv_lvl` and `v86_mode` hold.
- R11: While bit 0 of the word is clear, `priv_lvl` and `v86_mode` have no effect: every load is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gen_sel | input | 2 | Generation code: 0 oldest, 1 middle, 2 and 3 newest |
| load_req | input | 1 | Load strobe, one cycle per load |
| load_val | input | 16 | Load operand |
| priv_lvl | input | 2 | Current privilege level |
| v86_mode | input | 1 | Virtual-8086 flag |
| store_val | output | 16 | Formatted word for a store |
| pmode_on | output | 1 | Protected mode status (bit 0 of the word) |
| prot_fault | output | 1 | One-cycle protection fault strobe |

## Verification
A load and a store can fall in the same cycle. The store value is combinational from the held word, so the bench samples `store_val` in the request cycle and expects the old word in the current generation's format. After the edge it expects the new word. Generation, privilege level and virtual-8086 flag are swept against several operand patterns, starting with protection enable clear and starting with it set. In the cycle where a refused load would have written the word, the bench also checks that the fault strobe rises and the store value does not move.

// File: rtl/msw_pkg.sv
package msw_pkg;
   localparam int unsigned MSW_W = 16;
   typedef enum logic [1:0] {
      GEN_OLD = 2'd0,
      GEN_MID = 2'd1,
      GEN_NEW = 2'd2,
      GEN_ALT = 2'd3
   } gen_e;
endpackage

// File: rtl/msw_next.sv
module msw_next #(
   parameter int unsigned W        = 16,
   parameter int unsigned PE_BIT   = 0,
   parameter int unsigned KEEP_BIT = 4,
   parameter int unsigned OLD_W    = 4
) (
   input  logic [W-1:0] cur,
   input  logic [W-1:0] opnd,
   input  logic [1:0]   gen,
   output logic [W-1:0] nxt
);
   logic is_old;
   logic is_mid;
   assign is_old = (gen == msw_pkg::GEN_OLD);
   assign is_mid = (gen == msw_pkg::GEN_MID);

   for (genvar i = 0; i < W; i++) begin : g_bit
      if (i == PE_BIT) begin : g_pe
         assign nxt[i] = opnd[i] | cur[i];
      end else if (i == KEEP_BIT) begin : g_keep
         if (i >= OLD_W) begin : g_hi
            assign nxt[i] = is_mid ? cur[i] : (is_old ? 1'b0 : opnd[i]);
         end else begin : g_lo
            assign nxt[i] = is_mid ? cur[i] : opnd[i];
         end
      end else if (i >= OLD_W) begin : g_hi
         assign nxt[i] = is_old ? 1'b0 : opnd[i];
      end else begin : g_lo
         assign nxt[i] = opnd[i];
      end
   end
endmodule

// File: rtl/msw_store.sv
module msw_store #(
   parameter int unsigned W       = 16,
   parameter int unsigned MID_LO  = 8,
   parameter int unsigned OLD_LO  = 4
) (
   input  logic [W-1:0] cur,
   input  logic [1:0]   gen,
   output logic [W-1:0] sval
);
   localparam logic [W-1:0] MID_FILL = {W{1'b1}} << MID_LO;
   localparam logic [W-1:0] OLD_FILL = {W{1'b1}} << OLD_LO;

   always_comb begin
      unique case (gen)
         msw_pkg::GEN_OLD: sval = cur | OLD_FILL;
         msw_pkg::GEN_MID: sval = cur | MID_FILL;
         default:          sval = cur;
      endcase
   end
endmodule

// File: rtl/msw_guard.sv
module msw_guard #(
   parameter int unsigned PL_W = 2
) (
   input  logic            req,
   input  logic            pe_set,
   input  logic [PL_W-1:0] pl,
   input  logic            v86,
   output logic            deny,
   output logic            grant
);
   assign deny  = req & pe_set & ((|pl) | v86);
   assign grant = req & ~deny;
endmodule

// File: rtl/msw_ctrl.sv
module msw_ctrl #(
   parameter int unsigned W        = msw_pkg::MSW_W,
   parameter int unsigned PL_W     = 2,
   parameter int unsigned PE_BIT   = 0,
   parameter int unsigned KEEP_BIT = 4,
   parameter int unsigned OLD_W    = 4,
   parameter int unsigned MID_LO   = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [1:0]      gen_sel,
   input  logic            load_req,
   input  logic [W-1:0]    load_val,
   input  logic [PL_W-1:0] priv_lvl,
   input  logic            v86_mode,
   output logic [W-1:0]    store_val,
   output logic            pmode_on,
   output logic            prot_fault
);
   if (PE_BIT >= OLD_W) begin : g_bad_pe
      $error("PE_BIT must lie inside the oldest generation's field");
   end
   if (KEEP_BIT >= W || MID_LO > W || OLD_W > MID_LO) begin : g_bad_fill
      $error("bit positions out of range");
   end

   logic [W-1:0] msw_q;
   logic [W-1:0] msw_nxt;
   logic         deny;
   logic         grant;
   logic         fault_q;

   msw_guard #(.PL_W(PL_W)) guard_i (
      .req(load_req), .pe_set(msw_q[PE_BIT]), .pl(priv_lvl),
      .v86(v86_mode), .deny(deny), .grant(grant)
   );

   msw_next #(.W(W), .PE_BIT(PE_BIT), .KEEP_BIT(KEEP_BIT), .OLD_W(OLD_W)) next_i (
      .cur(msw_q), .opnd(load_val), .gen(gen_sel), .nxt(msw_nxt)
   );

   msw_store #(.W(W), .MID_LO(MID_LO), .OLD_LO(OLD_W)) store_i (
      .cur(msw_q), .gen(gen_sel), .sval(store_val)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         msw_q   <= '0;
         fault_q <= 1'b0;
      end else begin
         fault_q <= deny;
         if (grant) msw_q <= msw_nxt;
      end
   end

   assign pmode_on   = msw_q[PE_BIT];
   assign prot_fault = fault_q;
endmodule

// File: rtl/msw_ctrl_chk.sv
module msw_ctrl_chk #(
   parameter int unsigned W    = 16,
   parameter int unsigned PL_W = 2
) (
   input logic            clk,
   input logic            rst_n,
   input logic            load_req,
   input logic [PL_W-1:0] priv_lvl,
   input logic            v86_mode,
   input logic [W-1:0]    word,
   input logic            pmode_on,
   input logic            prot_fault
);
   a_r3_refused_faults: assert property (@(posedge clk) disable iff (!rst_n)
      (load_req && pmode_on && ((|priv_lvl) || v86_mode)) |=> prot_fault);

   a_r3_refused_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (load_req && pmode_on && ((|priv_lvl) || v86_mode)) |=> $stable(word));

   a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      !load_req |=> !prot_fault);

   a_r5_pe_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      pmode_on |=> pmode_on);

   a_r10_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !load_req |=> $stable(word));

   a_r11_no_fault_pe_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (load_req && !pmode_on) |=> !prot_fault);
endmodule

bind msw_ctrl msw_ctrl_chk #(.W(W), .PL_W(PL_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .load_req(load_req), .priv_lvl(priv_lvl),
   .v86_mode(v86_mode), .word(msw_q), .pmode_on(pmode_on), .prot_fault(prot_fault)
);

// File: tb/msw_ctrl_tb_top.sv
module msw_ctrl_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  gen_sel = 2'd2;
   logic        load_req = 1'b0;
   logic [15:0] load_val = '0;
   logic [1:0]  priv_lvl = '0;
   logic        v86_mode = 1'b0;
   logic [15:0] store_val;
   logic        pmode_on;
   logic        prot_fault;

   int checks = 0;
   int fails  = 0;
   logic [15:0] model = '0;

   always #10 clk = ~clk;

   msw_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .gen_sel(gen_sel), .load_req(load_req),
      .load_val(load_val), .priv_lvl(priv_lvl), .v86_mode(v86_mode),
      .store_val(store_val), .pmode_on(pmode_on), .prot_fault(prot_fault)
   );

   function automatic logic [15:0] fmt(input logic [15:0] w, input logic [1:0] g);
      if (g == 2'd0)      return w | 16'hFFF0;
      else if (g == 2'd1) return w | 16'hFF00;
      else                return w;
   endfunction

   function automatic logic [15:0] nxt(input logic [15:0] w, input logic [15:0] v,
                                       input logic [1:0] g);
      logic [15:0] t;
      t = v;
      if (w[0]) t[0] = 1'b1;
      if (g == 2'd1) t[4] = w[4];
      if (g == 2'd0) t = t & 16'h000F;
      return t;
   endfunction

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; load_req = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      model = '0;
   endtask

   task automatic do_load(input logic [1:0] g, input logic [15:0] v,
                          input logic [1:0] pl, input logic vm, input string tag);
      logic refuse;
      @(negedge clk);
      gen_sel = g; load_val = v; priv_lvl = pl; v86_mode = vm; load_req = 1'b1;
      #1;
      // load and store in one cycle: store still shows the old word
      chk({tag, " R8 store in load cycle"}, store_val, fmt(model, g));
      refuse = model[0] && ((pl != 2'd0) || vm);
      if (!refuse) model = nxt(model, v, g);
      @(posedge clk); #1;
      chk({tag, refuse ? " R3 refused word" : " R2 accepted word"}, store_val, fmt(model, g));
      chk({tag, " R4 fault strobe"}, {15'd0, prot_fault}, {15'd0, refuse});
      chk({tag, " R9 pmode"}, {15'd0, pmode_on}, {15'd0, model[0]});
      @(negedge clk);
      load_req = 1'b0;
      load_val = ~v; priv_lvl = ~pl; v86_mode = ~vm;
      @(posedge clk); #1;
      chk({tag, " R4 fault one cycle"}, {15'd0, prot_fault}, 16'd0);
      chk({tag, " R10 idle holds"}, store_val, fmt(model, g));
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin : main
      logic [15:0] pats [6];
      pats[0] = 16'h0000; pats[1] = 16'hFFFF; pats[2] = 16'h0010;
      pats[3] = 16'hA5A4; pats[4] = 16'h5A5B; pats[5] = 16'h00EE;

      do_reset();
      gen_sel = 2'd2;
      #1;
      chk("R1 reset store", store_val, 16'h0000);
      chk("R1 reset pmode", {15'd0, pmode_on}, 16'd0);
      chk("R1 reset fault", {15'd0, prot_fault}, 16'd0);

      for (int g = 0; g < 4; g++) begin
         for (int pe = 0; pe < 2; pe++) begin
            do_reset();
            // R11: nonzero privilege and v86 do not block while PE is clear
            do_load(g[1:0], 16'h0010, 2'd3, 1'b1, "R11 pe clear");
            if (pe == 1) do_load(g[1:0], 16'h0001, 2'd0, 1'b0, "R5 set pe");
            for (int pl = 0; pl < 4; pl++)
               for (int vm = 0; vm < 2; vm++)
                  for (int p = 0; p < 6; p++)
                     do_load(g[1:0], pats[p], pl[1:0], vm[0],
                             g == 0 ? "R7 oldest" : (g == 1 ? "R6 middle" : "R2 newest"));
            // R5: attempt to clear PE from privilege 0
            do_load(g[1:0], 16'h0000, 2'd0, 1'b0, "R5 clear attempt");
         end
      end

      // R4: back-to-back refused loads then a single-cycle drop
      do_reset();
      do_load(2'd2, 16'h0001, 2'd0, 1'b0, "R4 setup");
      @(negedge clk);
      load_req = 1'b1; priv_lvl = 2'd1; load_val = 16'h1234;
      @(posedge clk); #1;
      chk("R4 first refused", {15'd0, prot_fault}, 16'd1);
      @(posedge clk); #1;
      chk("R4 second refused", {15'd0, prot_fault}, 16'd1);
      chk("R3 word held", store_val, 16'h0001);
      @(negedge clk);
      load_req = 1'b0;
      @(posedge clk); #1;
      chk("R4 drop", {15'd0, prot_fault}, 16'd0);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule